// File: doc/BRIEF.md
# Audio FIFO Status and Interrupt Unit

This block sits between the host bus of a serial audio controller and its serial engine. It holds two small sample queues. The host fills the transmit queue and the serial engine drains it. The serial engine fills the receive queue and the host drains it. From the fill state of both queues the block builds a 32-bit status word and a single interrupt line. The status word carries both occupancy levels, not-full and not-empty flags, a busy flag, two threshold-based service requests and two sticky error flags.

Software programs the two service thresholds, the interrupt mask and the flag clear through one small configuration write port. The serial engine is represented by a stub: a one-cycle pop strobe with combinational data, a one-cycle push strobe, and a level that marks a frame in progress. Each of the two error flags and the two service requests can be routed to the interrupt separately.

Top module: `audio_fifo_status`

## Requirements
- R1: Status bits 15:12 hold the receive occupancy and bits 11:8 hold the transmit occupancy, each taken modulo 16, so a full 16-entry queue shows 0. Bits 31:16 and bit 7 are always 0.
- R2: A serial push into a receive queue that holds 16 entries at the edge sets status bit 6 and discards the sample. The bit stays set until a clear write has cfgWrData bit 6 = 1. When a set and a clear meet in the same cycle, the set wins.
- R3: A serial pop from an empty transmit queue sets status bit 5, returns serTxData = 0 and leaves the count unchanged. The bit stays set until a clear write has cfgWrData bit 5 = 1, and a set wins over a clear in the same cycle.
- R4: Status bit 4 is 1 exactly when enable = 1 and the receive count is greater than the receive threshold.
- R5: Status bit 3 is 1 exactly when enable = 1 and the transmit count is less than or equal to the transmit threshold.
- R6: Status bit 2 equals enable AND serBusy.
- R7: Status bit 1 is 1 when the receive queue is not empty. Status bit 0 is 1 when the transmit queue holds fewer than 16 entries.
- R8: irq is a register. It is loaded with the OR of (status bits 6..3 AND mask bits 6..3) from the cycle before, so it follows the status by one clock.
- R9: After reset, status reads 0x00000001 and irq is 0. The mask and both thresholds reset to 0.
- R10: Both queues are first-in first-out. A host write to a full transmit queue is dropped. A host read of an empty receive queue returns rxRdData = 0. Read data is the head entry, presented combinationally while the read strobe is high.
- R11: A configuration write uses cfgSel to pick the target. cfgSel 0 writes the thresholds: transmit threshold in cfgWrData 3:0 and receive threshold in 7:4. cfgSel 1 writes the mask, of which cfgWrData bits 6..3 are kept. cfgSel 2 is the clear. cfgSel 3 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable |
| serBusy | input | 1 | Serial stub: frame in progress |
| txWrEn | input | 1 | Host write strobe, transmit queue |
| txWrData | input | DATA_W | Host write data |
| rxRdEn | input | 1 | Host read strobe, receive queue |
| rxRdData | output | DATA_W | Receive head data, 0 when empty |
| serTxRd | input | 1 | Serial stub pop strobe, transmit queue |
| serTxData | output | DATA_W | Transmit head data, 0 when empty |
| serRxWr | input | 1 | Serial stub push strobe, receive queue |
| serRxData | input | DATA_W | Serial stub push data |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target select |
| cfgWrData | input | 8 | Configuration write data |
| status | output | 32 | Status word |
| irq | output | 1 | Masked, registered interrupt |

## Verification
The bench builds the block with its default values: 16-bit samples and queues 16 entries deep. With that depth, random phases of skewed push and pop rates drive both queues into full and empty states many times. This brings overrun, underrun, the level field wrapping to 0, and the threshold edges of both service requests within reach. Random threshold, mask and clear writes, combined with enable toggling, reach the cases where a flag is set and cleared in the same cycle and where the interrupt rises and falls.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int LVL_W  = 4;
  localparam int CFG_W  = 8;
  localparam int STAT_W = 32;

  typedef enum logic [1:0] {
    CFG_THRESH = 2'd0,
    CFG_MASK   = 2'd1,
    CFG_CLEAR  = 2'd2,
    CFG_NONE   = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic setOvr;
    logic setUnd;
    logic clrOvr;
    logic clrUnd;
    logic thrWr;
    logic maskWr;
  } afsStrobes_t;
endpackage

// File: rtl/afs_fifo.sv
module afs_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign rdData = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/afs_ctrl.sv
module afs_ctrl
  import afs_pkg::*;
(
  input  logic        txWrEn,
  input  logic        serTxRd,
  input  logic        serRxWr,
  input  logic        rxRdEn,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgSel,
  input  logic [1:0]  clrBits,
  input  logic        txFull,
  input  logic        txEmpty,
  input  logic        rxFull,
  input  logic        rxEmpty,
  output afsStrobes_t strobes
);
  logic isClear;

  assign isClear = cfgWrEn && (cfgSel == CFG_CLEAR);

  always_comb begin
    strobes        = '0;
    strobes.txPush = txWrEn && !txFull;
    strobes.txPop  = serTxRd && !txEmpty;
    strobes.setUnd = serTxRd && txEmpty;
    strobes.rxPush = serRxWr && !rxFull;
    strobes.setOvr = serRxWr && rxFull;
    strobes.rxPop  = rxRdEn && !rxEmpty;
    strobes.clrOvr = isClear && clrBits[1];
    strobes.clrUnd = isClear && clrBits[0];
    strobes.thrWr  = cfgWrEn && (cfgSel == CFG_THRESH);
    strobes.maskWr = cfgWrEn && (cfgSel == CFG_MASK);
  end
endmodule

// File: rtl/afs_datapath.sv
module afs_datapath
  import afs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              serBusy,
  input  afsStrobes_t       strobes,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] serRxData,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [DATA_W-1:0] rxRdData,
  output logic [DATA_W-1:0] serTxData,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [CNT_W-1:0] txCount, rxCount;
  logic [LVL_W-1:0] txThresh, rxThresh;
  logic [3:0]       maskReg;
  logic             ovrFlag, undFlag;
  logic             rxReq, txReq;

  afs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(strobes.txPush), .pop(strobes.txPop),
    .wrData(txWrData), .rdData(serTxData), .count(txCount),
    .full(txFull), .empty(txEmpty));

  afs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(strobes.rxPush), .pop(strobes.rxPop),
    .wrData(serRxData), .rdData(rxRdData), .count(rxCount),
    .full(rxFull), .empty(rxEmpty));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrFlag  <= 1'b0;
      undFlag  <= 1'b0;
      txThresh <= '0;
      rxThresh <= '0;
      maskReg  <= '0;
      irq      <= 1'b0;
    end else begin
      ovrFlag <= strobes.setOvr || (ovrFlag && !strobes.clrOvr);
      undFlag <= strobes.setUnd || (undFlag && !strobes.clrUnd);
      if (strobes.thrWr) begin
        txThresh <= cfgWrData[3:0];
        rxThresh <= cfgWrData[7:4];
      end
      if (strobes.maskWr) maskReg <= cfgWrData[6:3];
      irq <= |(status[6:3] & maskReg);
    end
  end

  assign rxReq = enable && (rxCount > CNT_W'(rxThresh));
  assign txReq = enable && (txCount <= CNT_W'(txThresh));

  always_comb begin
    status        = '0;
    status[15:12] = LVL_W'(rxCount);
    status[11:8]  = LVL_W'(txCount);
    status[6]     = ovrFlag;
    status[5]     = undFlag;
    status[4]     = rxReq;
    status[3]     = txReq;
    status[2]     = enable && serBusy;
    status[1]     = !rxEmpty;
    status[0]     = !txFull;
  end
endmodule

// File: rtl/audio_fifo_status.sv
module audio_fifo_status
  import afs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              serBusy,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxRdData,
  input  logic              serTxRd,
  output logic [DATA_W-1:0] serTxData,
  input  logic              serRxWr,
  input  logic [DATA_W-1:0] serRxData,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  afsStrobes_t strobes;
  logic txFull, txEmpty, rxFull, rxEmpty;

  afs_ctrl u_ctrl (
    .txWrEn(txWrEn), .serTxRd(serTxRd), .serRxWr(serRxWr), .rxRdEn(rxRdEn),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .clrBits(cfgWrData[6:5]),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .strobes(strobes));

  afs_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .serBusy(serBusy),
    .strobes(strobes), .txWrData(txWrData), .serRxData(serRxData),
    .cfgWrData(cfgWrData), .rxRdData(rxRdData), .serTxData(serTxData),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .status(status), .irq(irq));
endmodule

// File: rtl/afs_checker.sv
module afs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        serBusy,
  input logic        serRxWr,
  input logic        serTxRd,
  input logic        cfgWrEn,
  input logic [1:0]  cfgSel,
  input logic [7:0]  cfgWrData,
  input logic [31:0] status,
  input logic        irq
);
  logic rxIsFull, txIsEmpty, clrOvrW, clrUndW;

  assign rxIsFull  = status[1] && (status[15:12] == 4'd0);
  assign txIsEmpty = status[0] && (status[11:8] == 4'd0);
  assign clrOvrW   = cfgWrEn && (cfgSel == 2'd2) && cfgWrData[6];
  assign clrUndW   = cfgWrEn && (cfgSel == 2'd2) && cfgWrData[5];

  // R1
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (status[31:16] == 16'd0) && !status[7]);
  // R2
  a_r2_ovr_sets: assert property (@(posedge clk) disable iff (!rstN)
    serRxWr && rxIsFull |=> status[6]);
  a_r2_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    status[6] && !clrOvrW |=> status[6]);
  // R3
  a_r3_und_sets: assert property (@(posedge clk) disable iff (!rstN)
    serTxRd && txIsEmpty |=> status[5]);
  a_r3_und_sticky: assert property (@(posedge clk) disable iff (!rstN)
    status[5] && !clrUndW |=> status[5]);
  // R4, R5, R6
  a_r4_off_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !status[4] && !status[3] && !status[2]);
  a_r6_busy_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    status[2] |-> serBusy);
  // R7
  a_r7_empty_level: assert property (@(posedge clk) disable iff (!rstN)
    !status[1] |-> status[15:12] == 4'd0);
  // R8
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(|status[6:3]));
endmodule

bind audio_fifo_status afs_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .serBusy(serBusy),
  .serRxWr(serRxWr), .serTxRd(serTxRd), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
  .cfgWrData(cfgWrData), .status(status), .irq(irq));

// File: tb/audio_fifo_status_tb.sv
module audio_fifo_status_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN;
  logic enable, serBusy, txWrEn, rxRdEn, serTxRd, serRxWr, cfgWrEn;
  logic [DW-1:0] txWrData, serRxData, rxRdData, serTxData;
  logic [1:0] cfgSel;
  logic [7:0] cfgWrData;
  logic [31:0] status;
  logic irq;

  always #4 clk = ~clk;

  audio_fifo_status u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .serBusy(serBusy),
    .txWrEn(txWrEn), .txWrData(txWrData), .rxRdEn(rxRdEn), .rxRdData(rxRdData),
    .serTxRd(serTxRd), .serTxData(serTxData), .serRxWr(serRxWr),
    .serRxData(serRxData), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .status(status), .irq(irq));

  int checks = 0, fails = 0;
  bit done = 0;

  // model
  logic [DW-1:0] tq [16], rq [16];
  int tHead, tCnt, rHead, rCnt;
  bit ovr, und, mIrq;
  int txTh, rxTh;
  logic [3:0] mask;

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    s[15:12] = 4'(rCnt);
    s[11:8]  = 4'(tCnt);
    s[6] = ovr;
    s[5] = und;
    s[4] = enable && (rCnt > rxTh);
    s[3] = enable && (tCnt <= txTh);
    s[2] = enable && serBusy;
    s[1] = (rCnt != 0);
    s[0] = (tCnt != 16);
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkStatus();
    logic [31:0] e = expStatus();
    chk("R1 levels/reserved", {status[31:16], status[15:7]}, {e[31:16], e[15:7]});
    chk("R2 overrun", 32'(status[6]), 32'(e[6]));
    chk("R3 underrun", 32'(status[5]), 32'(e[5]));
    chk("R4 rx request", 32'(status[4]), 32'(e[4]));
    chk("R5 tx request", 32'(status[3]), 32'(e[3]));
    chk("R6 busy", 32'(status[2]), 32'(e[2]));
    chk("R7 not-empty/not-full", 32'(status[1:0]), 32'(e[1:0]));
    chk("R8 irq", 32'(irq), 32'(mIrq));
  endtask

  // apply the coming edge to the model (inputs already driven)
  task automatic stepModel();
    logic [31:0] sNow = expStatus();
    bit tPush = txWrEn && tCnt < 16;
    bit tPop  = serTxRd && tCnt > 0;
    bit rPush = serRxWr && rCnt < 16;
    bit rPop  = rxRdEn && rCnt > 0;
    bit clr   = cfgWrEn && cfgSel == 2'd2;
    mIrq = |(sNow[6:3] & mask);
    ovr = (serRxWr && rCnt == 16) || (ovr && !(clr && cfgWrData[6]));
    und = (serTxRd && tCnt == 0) || (und && !(clr && cfgWrData[5]));
    if (cfgWrEn && cfgSel == 2'd0) begin txTh = cfgWrData[3:0]; rxTh = cfgWrData[7:4]; end
    if (cfgWrEn && cfgSel == 2'd1) mask = cfgWrData[6:3];
    if (tPush) tq[(tHead + tCnt) % 16] = txWrData;
    if (tPop) tHead = (tHead + 1) % 16;
    tCnt += int'(tPush) - int'(tPop);
    if (rPush) rq[(rHead + rCnt) % 16] = serRxData;
    if (rPop) rHead = (rHead + 1) % 16;
    rCnt += int'(rPush) - int'(rPop);
  endtask

  task automatic checkData();
    if (serTxRd) chk("R10/R3 tx data", 32'(serTxData), (tCnt > 0) ? 32'(tq[tHead]) : 32'd0);
    if (rxRdEn)  chk("R10 rx data", 32'(rxRdData), (rCnt > 0) ? 32'(rq[rHead]) : 32'd0);
  endtask

  task automatic idleInputs();
    {enable, serBusy, txWrEn, rxRdEn, serTxRd, serRxWr, cfgWrEn} = '0;
    txWrData = '0; serRxData = '0; cfgSel = 2'd3; cfgWrData = '0;
  endtask

  task automatic cycle();
    #1 checkData();
    stepModel();
    @(negedge clk);
    checkStatus();
  endtask

  task summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int pTw, pTr, pRw, pRr;
    void'($urandom(32'd20240611));
    idleInputs();
    rstN = 1'b0;
    tHead = 0; tCnt = 0; rHead = 0; rCnt = 0;
    ovr = 0; und = 0; mIrq = 0; txTh = 0; rxTh = 0; mask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset status", status, 32'h0000_0001);
    chk("R9 reset irq", 32'(irq), 32'd0);

    // directed: fill rx to 16 with enable, threshold 15, mask all
    enable = 1; cfgWrEn = 1; cfgSel = 2'd0; cfgWrData = 8'hF2;
    cycle();
    cfgSel = 2'd1; cfgWrData = 8'h78;
    cycle();
    cfgWrEn = 0;
    for (int i = 0; i < 17; i++) begin
      serRxWr = 1; serRxData = DW'(16'hA000 + i);
      cycle();
    end
    serRxWr = 0;
    chk("R1 full rx level shows 0", 32'(status[15:12]), 32'd0);
    chk("R2 overrun after 17th push", 32'(status[6]), 32'd1);
    // directed: underrun and same-cycle set/clear (set wins)
    serTxRd = 1; cfgWrEn = 1; cfgSel = 2'd2; cfgWrData = 8'h20;
    cycle();
    chk("R3 set wins over clear", 32'(status[5]), 32'd1);
    serTxRd = 0;
    cycle();
    chk("R3 cleared", 32'(status[5]), 32'd0);
    cfgSel = 2'd3; cfgWrData = 8'hFF;
    cycle();
    chk("R11 sel 3 no effect", 32'(status[6]), 32'd1);
    cfgWrEn = 0;

    // random phases
    for (int ph = 0; ph < 24; ph++) begin
      pTw = 10 + 40 * ($urandom % 3); pTr = 10 + 40 * ($urandom % 3);
      pRw = 10 + 40 * ($urandom % 3); pRr = 10 + 40 * ($urandom % 3);
      for (int c = 0; c < 120; c++) begin
        enable   = ($urandom % 100) < 90;
        serBusy  = $urandom % 2;
        txWrEn   = ($urandom % 100) < pTw;
        serTxRd  = ($urandom % 100) < pTr;
        serRxWr  = ($urandom % 100) < pRw;
        rxRdEn   = ($urandom % 100) < pRr;
        txWrData = DW'($urandom);
        serRxData = DW'($urandom);
        cfgWrEn  = ($urandom % 100) < 8;
        cfgSel   = 2'($urandom);
        cfgWrData = 8'($urandom);
        cycle();
      end
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule